// File: doc/BRIEF.md
# Half-Bridge Driver Serial Command and Status Port

This block is the synchronous serial slave of a driver for three half-bridges. A host frames each transfer with an active-low select line. During a frame it shifts a 16-bit command word in, least significant bit first, and the port shifts a 16-bit status word out on a data line that is only driven while the frame is open. The serial select, clock and data pins are asynchronous to the core. They pass through synchronizers, and their edges are found on a system clock that must run at least eight times faster than the serial clock.

The status word is a snapshot of the core's flags taken when the frame opens. Its lowest bit, the temperature warning, is on the output line before any clock edge, so a host can read it by dropping select and raising it again. A received command is handed to the control core only when select rises after exactly sixteen serial clock falling edges. Any shorter or longer frame leaves the command outputs untouched.

Top module: `hbsp_port`

## Requirements
- R1: After reset the six switch enables and the flag-clear output are 0, the overcurrent-shutdown enable is 1, `sdo_en` is 0 and `cmd_strobe` is 0.
- R2: While select (`spi_csn`) is high, `sdo_en` is 0 and `sdo` is 0. While a frame is open, `sdo_en` is 1.
- R3: Once select falls, `sdo` carries the temperature-warning flag captured at that moment, with no serial clock edge needed.
- R4: Status word layout: bit 0 is the temperature warning, bits 1 to 6 are `sw_state[0..5]`, bit 13 is short detected, bit 14 is open load, bit 15 is supply fail, and bits 7 to 12 read 0. `sdo` moves to the next bit on each rising serial clock edge that follows at least one falling edge in the frame. Bit k is therefore valid before the (k+1)-th falling edge.
- R5: `sdi` is sampled on falling serial clock edges, first bit as bit 0. When a frame with exactly 16 falling edges closes, bit 0 loads `clear_flags`, bits 1 to 6 load `sw_enable[0..5]` (low side of bridges 1 to 3 at indices 0, 2 and 4, high side at 1, 3 and 5), and bit 13 loads `ocs_enable`. All other bits are ignored.
- R6: Each committed frame raises `cmd_strobe` for exactly one system clock cycle. The command outputs change only in that cycle.
- R7: A frame that closes after any count of falling edges other than 16 changes no command output and gives no strobe. This covers a count of 0 (temperature poll), a short frame, and a long frame that includes counts above 31.
- R8: The status word shifted out is the one captured when the frame opened. Changes on the status inputs during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Asynchronous active-low frame select |
| spi_sck | input | 1 | Asynchronous serial clock, idles low |
| spi_sdi | input | 1 | Asynchronous serial command data |
| sdo | output | 1 | Serial status data |
| sdo_en | output | 1 | Output enable for the status data pad driver |
| temp_warn | input | 1 | Core temperature-warning flag |
| sw_state | input | 6 | Actual on/off state of the six switches |
| short_det | input | 1 | Core short-circuit flag |
| open_load | input | 1 | Core open-load flag |
| supply_fail | input | 1 | Core supply-undervoltage flag |
| clear_flags | output | 1 | Committed request to clear the core's latched flags |
| sw_enable | output | 6 | Committed switch enables |
| ocs_enable | output | 1 | Committed overcurrent-shutdown enable |
| cmd_strobe | output | 1 | One-cycle pulse when a command is committed |

## Verification
A wrong edge count shows first at the close of a frame. A long or short frame then commits a command or raises the strobe, or a valid frame fails to do either, and the effect is visible within a few system cycles of select rising. A shift register that is off by one position shows at once in the status bits read back during the same frame, and in the command fields after the next commit. A wrong snapshot or a wrong enable state appears on `sdo` at the moment select falls, before any clock.

// File: rtl/hbsp_pkg.sv
package hbsp_pkg;

    localparam int NUM_BRIDGES = 3;
    localparam int SW_W        = 2 * NUM_BRIDGES;
    localparam int FRAME_BITS  = 16;
    localparam int CNT_W       = $clog2(FRAME_BITS) + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

    // bit positions that the host side decodes
    localparam int POS_CLEAR  = 0;
    localparam int POS_SW_LO  = 1;
    localparam int POS_OCS    = 13;
    localparam int POS_TEMP   = 0;
    localparam int POS_SHORT  = 13;
    localparam int POS_OPEN   = 14;
    localparam int POS_SUPPLY = 15;

    typedef logic [FRAME_BITS-1:0] word_t;

    typedef struct packed {
        logic            clear;
        logic [SW_W-1:0] sw;
        logic            ocs;
    } cmd_t;

    typedef struct packed {
        logic            temp;
        logic [SW_W-1:0] sw;
        logic            short_c;
        logic            open_c;
        logic            supply;
    } stat_t;

    localparam cmd_t CMD_RESET = '{clear: 1'b0, sw: '0, ocs: 1'b1};

    function automatic cmd_t decode_cmd(input word_t w);
        cmd_t c;
        c.clear = w[POS_CLEAR];
        c.sw    = w[POS_SW_LO +: SW_W];
        c.ocs   = w[POS_OCS];
        return c;
    endfunction

    function automatic word_t pack_status(input stat_t s);
        word_t w;
        w = '0;
        w[POS_TEMP]          = s.temp;
        w[POS_SW_LO +: SW_W] = s.sw;
        w[POS_SHORT]         = s.short_c;
        w[POS_OPEN]          = s.open_c;
        w[POS_SUPPLY]        = s.supply;
        return w;
    endfunction

endpackage

// File: rtl/hbsp_sync.sv
module hbsp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= d;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbsp_edge.sv
module hbsp_edge #(
    parameter int WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/hbsp_rx.sv
module hbsp_rx
    import hbsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             frame_open,
    input  logic             frame_close,
    input  logic             sck_fall,
    input  logic             sdi,
    output logic [CNT_W-1:0] bit_cnt,
    output cmd_t             cmd,
    output logic             strobe
);
    word_t            shift_q;
    logic [CNT_W-1:0] cnt_q;
    cmd_t             cmd_q;
    logic             strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (frame_open) begin
            cnt_q   <= '0;
        end else if (active && sck_fall) begin
            shift_q <= {sdi, shift_q[FRAME_BITS-1:1]};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_RESET;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (frame_close && cnt_q == CNT_FULL) begin
                cmd_q    <= decode_cmd(shift_q);
                strobe_q <= 1'b1;
            end
        end
    end

    assign bit_cnt = cnt_q;
    assign cmd     = cmd_q;
    assign strobe  = strobe_q;
endmodule

// File: rtl/hbsp_tx.sv
module hbsp_tx
    import hbsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             frame_open,
    input  logic             frame_close,
    input  logic             sck_rise,
    input  logic [CNT_W-1:0] bit_cnt,
    input  stat_t            status,
    output logic             sdo,
    output logic             sdo_en
);
    word_t sr_q;
    logic  en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            en_q <= 1'b0;
        end else if (frame_open) begin
            sr_q <= pack_status(status);
            en_q <= 1'b1;
        end else if (frame_close) begin
            en_q <= 1'b0;
        end else if (active && sck_rise && bit_cnt != '0) begin
            sr_q <= {1'b0, sr_q[FRAME_BITS-1:1]};
        end
    end

    assign sdo    = en_q & sr_q[0];
    assign sdo_en = en_q;
endmodule

// File: rtl/hbsp_port.sv
module hbsp_port
    import hbsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            spi_csn,
    input  logic            spi_sck,
    input  logic            spi_sdi,
    output logic            sdo,
    output logic            sdo_en,
    input  logic            temp_warn,
    input  logic [SW_W-1:0] sw_state,
    input  logic            short_det,
    input  logic            open_load,
    input  logic            supply_fail,
    output logic            clear_flags,
    output logic [SW_W-1:0] sw_enable,
    output logic            ocs_enable,
    output logic            cmd_strobe
);
    logic [2:0]       pins_s;
    logic             csn_s, sck_s, sdi_s;
    logic [1:0]       rise_v, fall_v;
    logic [CNT_W-1:0] bit_cnt;
    cmd_t             cmd;
    stat_t            status;

    // order: {csn, sck, sdi}; select idles high
    hbsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_csn, spi_sck, spi_sdi}),
        .q   (pins_s)
    );
    assign {csn_s, sck_s, sdi_s} = pins_s;

    hbsp_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({csn_s, sck_s}),
        .rise (rise_v),
        .fall (fall_v)
    );

    assign status = '{temp: temp_warn, sw: sw_state, short_c: short_det,
                      open_c: open_load, supply: supply_fail};

    hbsp_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .active      (~csn_s),
        .frame_open  (fall_v[1]),
        .frame_close (rise_v[1]),
        .sck_fall    (fall_v[0]),
        .sdi         (sdi_s),
        .bit_cnt     (bit_cnt),
        .cmd         (cmd),
        .strobe      (cmd_strobe)
    );

    hbsp_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .active      (~csn_s),
        .frame_open  (fall_v[1]),
        .frame_close (rise_v[1]),
        .sck_rise    (rise_v[0]),
        .bit_cnt     (bit_cnt),
        .status      (status),
        .sdo         (sdo),
        .sdo_en      (sdo_en)
    );

    assign clear_flags = cmd.clear;
    assign sw_enable   = cmd.sw;
    assign ocs_enable  = cmd.ocs;
endmodule

// File: rtl/hbsp_checker.sv
module hbsp_checker
    import hbsp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sdo,
    input logic             sdo_en,
    input logic             temp_warn,
    input logic             cmd_strobe,
    input logic [SW_W-1:0]  sw_enable,
    input logic             ocs_enable,
    input logic             clear_flags,
    input logic [CNT_W-1:0] bit_cnt
);
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (sw_enable == '0 && !clear_flags && ocs_enable && !sdo_en && !cmd_strobe));

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo);

    a_r3_warn_at_open: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> (sdo == $past(temp_warn)));

    a_r5_commit_full_count: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> (bit_cnt == CNT_FULL));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    a_r7_change_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !($stable(sw_enable) && $stable(ocs_enable) && $stable(clear_flags)) |-> cmd_strobe);
endmodule

bind hbsp_port hbsp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sdo         (sdo),
    .sdo_en      (sdo_en),
    .temp_warn   (temp_warn),
    .cmd_strobe  (cmd_strobe),
    .sw_enable   (sw_enable),
    .ocs_enable  (ocs_enable),
    .clear_flags (clear_flags),
    .bit_cnt     (bit_cnt)
);

// File: tb/hbsp_port_tb.sv
module hbsp_port_tb;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
    logic sdo, sdo_en;
    logic temp_warn = 1'b0;
    logic [5:0] sw_state = '0;
    logic short_det = 1'b0, open_load = 1'b0, supply_fail = 1'b0;
    logic clear_flags, ocs_enable, cmd_strobe;
    logic [5:0] sw_enable;

    int n_chk = 0, n_bad = 0;
    int strobes = 0, double_pulse = 0;
    logic prev_strobe = 1'b0;
    bit done = 0;

    logic       e_clear = 1'b0, e_ocs = 1'b1;
    logic [5:0] e_sw = '0;

    always #2.5 clk = ~clk;

    hbsp_port u_dut (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .sdo(sdo), .sdo_en(sdo_en), .temp_warn(temp_warn), .sw_state(sw_state),
        .short_det(short_det), .open_load(open_load), .supply_fail(supply_fail),
        .clear_flags(clear_flags), .sw_enable(sw_enable), .ocs_enable(ocs_enable),
        .cmd_strobe(cmd_strobe)
    );

    always @(posedge clk) begin
        if (cmd_strobe) strobes++;
        if (cmd_strobe && prev_strobe) double_pulse++;
        prev_strobe <= cmd_strobe;
    end

    function automatic logic [15:0] exp_status(input logic tw, input logic [5:0] sw,
                                               input logic sc, input logic ol, input logic sf);
        return {sf, ol, sc, 6'b0, sw, tw};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_status_rand();
        temp_warn   = 1'($urandom);
        sw_state    = 6'($urandom);
        short_det   = 1'($urandom);
        open_load   = 1'($urandom);
        supply_fail = 1'($urandom);
    endtask

    // nedges falling clock edges; status inputs randomised after edge chg_at
    task automatic frame(input logic [15:0] cmd, input int nedges, input int chg_at);
        logic [15:0] snap, rd;
        int s0;
        snap = exp_status(temp_warn, sw_state, short_det, open_load, supply_fail);
        rd = '0;
        s0 = strobes;
        spi_csn = 1'b0;
        wait_sys(HP);
        check("R2 enable in frame", 32'(sdo_en), 32'd1);
        check("R3 warn before clock", 32'(sdo), 32'(snap[0]));
        for (int i = 0; i < nedges; i++) begin
            spi_sck = 1'b1;
            spi_sdi = (i < 16) ? cmd[i] : 1'b0;
            wait_sys(HP);
            if (i < 16) rd[i] = sdo;
            spi_sck = 1'b0;
            wait_sys(HP);
            if (i == chg_at) set_status_rand();
        end
        spi_csn = 1'b1;
        wait_sys(2 * HP);
        if (nedges >= 16) check("R4 R8 status word", 32'(rd), 32'(snap));
        if (nedges == 16) begin
            e_clear = cmd[0]; e_sw = cmd[6:1]; e_ocs = cmd[13];
            check("R6 one strobe", 32'(strobes - s0), 32'd1);
        end else begin
            check("R7 no strobe", 32'(strobes - s0), 32'd0);
        end
        check("R5 R7 switch enables", 32'(sw_enable), 32'(e_sw));
        check("R5 R7 ocs enable", 32'(ocs_enable), 32'(e_ocs));
        check("R5 R7 clear flags", 32'(clear_flags), 32'(e_clear));
        check("R2 idle enable", 32'(sdo_en), 32'd0);
        check("R2 idle data", 32'(sdo), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_sys(4);
        rst = 1'b0;
        wait_sys(2);
        // R1 reset state
        check("R1 switch enables", 32'(sw_enable), 32'd0);
        check("R1 clear flags", 32'(clear_flags), 32'd0);
        check("R1 ocs enable", 32'(ocs_enable), 32'd1);
        check("R1 sdo_en", 32'(sdo_en), 32'd0);
        check("R1 strobe", 32'(strobes), 32'd0);

        // directed: full command with ignored bits set, R5
        temp_warn = 1'b1; sw_state = 6'b101010; short_det = 1'b1; open_load = 1'b0; supply_fail = 1'b1;
        frame(16'hDF81 & ~16'h2000 | 16'h1F80 | 16'h0015, 16, -1);
        // R7 temperature poll: zero edges
        temp_warn = 1'b0;
        frame(16'hFFFF, 0, -1);
        temp_warn = 1'b1;
        frame(16'hFFFF, 0, -1);
        // R7 short and long frames, including saturation past 31
        frame(16'h207E, 15, -1);
        frame(16'h207E, 1, -1);
        frame(16'h207E, 17, -1);
        frame(16'h207E, 33, -1);
        // R8 status inputs change mid-frame
        frame(16'h0042, 16, 4);
        // all ones: R5 every field set
        frame(16'hFFFF, 16, -1);

        for (int k = 0; k < 40; k++) begin
            int sel, n;
            set_status_rand();
            sel = int'($urandom % 8);
            case (sel)
                5: n = 15;
                6: n = 3;
                7: n = 33;
                default: n = 16;
            endcase
            frame(16'($urandom), n, (k % 5 == 0) ? 7 : -1);
        end

        check("R6 pulse width", 32'(double_pulse), 32'd0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule